// File: doc/BRIEF.md
# Address Map Decoder with Access Fault Response

This block sits between a 32-bit microcontroller bus and its targets. For every request it classifies the address into one of ten memory or peripheral windows, presents a one-hot window select at once, and, for the peripheral windows, splits the address into a 16 kB slot number and a word-aligned register offset inside that slot.

Each request also decides whether the access is legal. Addresses that fall in no window fault, whether the access is a data access or an instruction fetch. An instruction fetch from a peripheral window faults, although a data access to the same address is legal. A write to the flash window faults. Offsets inside an existing peripheral slot never fault: only the offset bits reach the slot, so undefined offsets alias onto defined registers.

One cycle after a request is accepted, a registered response comes back with a ready flag, an error flag and the request's tag. The flash and local SRAM window sizes are parameters. Space above the configured size inside the same window is reserved.

Top module: `memmap_decode`

## Requirements
- R1: `region_sel` is one-hot or all zero. Bit 0 is flash (base 0x0000_0000), bit 1 local SRAM (base 0x1000_0000), bit 2 boot ROM (0x1FFF_0000–0x1FFF_1FFF), bit 3 SRAM bank 0 (0x2007_C000–0x2007_FFFF), bit 4 SRAM bank 1 (0x2008_0000–0x2008_3FFF), bit 5 GPIO (0x2009_C000–0x2009_FFFF), bit 6 low APB window (0x4000_0000–0x4007_FFFF), bit 7 high APB window (0x4008_0000–0x400F_FFFF), bit 8 AHB peripheral window (0x5000_0000–0x501F_FFFF), and bit 9 private peripheral window (0xE000_0000–0xE00F_FFFF). It follows `req_addr` in the same cycle.
- R2: The flash window spans FLASH_BYTES bytes and the local SRAM window spans LSRAM_BYTES bytes (defaults 512 kB and 32 kB). An address at or above base plus size selects nothing and faults.
- R3: An address in no window selects nothing and faults, for both data accesses and instruction fetches.
- R4: An instruction fetch with `region_sel` bit 6, 7 or 8 set faults. A data access to those windows does not fault, and neither does a fetch from any other window.
- R5: A write with `region_sel` bit 0 set faults. A read or fetch from flash does not fault.
- R6: In windows 6, 7 and 8, `slot_idx` equals address bits [20:14]: low APB gives 0–31, high APB gives 32–63, and AHB peripherals give 0–127. In all other cases it is 0.
- R7: In windows 6, 7 and 8, `reg_off` equals address bits [13:2], and no offset inside a slot faults. In all other cases it is 0.
- R8: A request accepted at a clock edge gives `rsp_valid`=1, `rsp_tag` equal to the request's tag, and `rsp_err` equal to its fault decision after that edge. Without a request, `rsp_valid` and `rsp_err` are 0.
- R9: While `rst_n` is low, `rsp_valid` and `rsp_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_fetch | input | 1 | 1 for instruction fetch |
| req_tag | input | TAG_W | Request tag returned with the response |
| region_sel | output | 10 | One-hot window select, zero when reserved |
| slot_idx | output | 7 | Peripheral slot number |
| reg_off | output | 12 | Word offset inside the slot |
| rsp_valid | output | 1 | Response ready flag |
| rsp_err | output | 1 | Response error flag |
| rsp_tag | output | TAG_W | Tag of the answered request |

## Verification
The assertions check on every cycle that the select is at most one-hot and that a response follows each request with the tag it carried. They also check that a fetch into a peripheral window, a write into flash, or an address that selects nothing always returns an error, and that slot and offset stay zero outside the peripheral windows. Only the bench scenarios can show that each window's exact boundaries, the parameter-sized flash and SRAM limits, and the slot and offset values for particular addresses are correct. The same holds for the silent aliasing of undefined offsets.

// File: rtl/memmap_decode.sv
module memmap_decode #(
  parameter int FLASH_BYTES = 524288,
  parameter int LSRAM_BYTES = 32768,
  parameter int TAG_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [31:0]      req_addr,
  input  logic             req_write,
  input  logic             req_fetch,
  input  logic [TAG_W-1:0] req_tag,
  output logic [9:0]       region_sel,
  output logic [6:0]       slot_idx,
  output logic [11:0]      reg_off,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [TAG_W-1:0] rsp_tag
);
  localparam logic [31:0] LSRAM_BASE = 32'h1000_0000;
  localparam logic [31:0] FLASH_END  = 32'(FLASH_BYTES);
  localparam logic [31:0] LSRAM_END  = LSRAM_BASE + 32'(LSRAM_BYTES);

  function automatic logic in_rng(input logic [31:0] a, input logic [31:0] lo,
                                  input logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  assign region_sel[0] = req_addr < FLASH_END;
  assign region_sel[1] = (req_addr >= LSRAM_BASE) && (req_addr < LSRAM_END);
  assign region_sel[2] = in_rng(req_addr, 32'h1FFF_0000, 32'h1FFF_1FFF);
  assign region_sel[3] = in_rng(req_addr, 32'h2007_C000, 32'h2007_FFFF);
  assign region_sel[4] = in_rng(req_addr, 32'h2008_0000, 32'h2008_3FFF);
  assign region_sel[5] = in_rng(req_addr, 32'h2009_C000, 32'h2009_FFFF);
  assign region_sel[6] = in_rng(req_addr, 32'h4000_0000, 32'h4007_FFFF);
  assign region_sel[7] = in_rng(req_addr, 32'h4008_0000, 32'h400F_FFFF);
  assign region_sel[8] = in_rng(req_addr, 32'h5000_0000, 32'h501F_FFFF);
  assign region_sel[9] = in_rng(req_addr, 32'hE000_0000, 32'hE00F_FFFF);

  logic periph, fault;
  assign periph   = |region_sel[8:6];
  assign slot_idx = periph ? req_addr[20:14] : 7'd0;
  assign reg_off  = periph ? req_addr[13:2]  : 12'd0;

  assign fault = ~|region_sel
               | (req_fetch & periph)
               | (req_write & region_sel[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_tag   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid & fault;
      if (req_valid) rsp_tag <= req_tag;
    end
  end
endmodule

// File: rtl/memmap_decode_chk.sv
module memmap_decode_chk #(
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             req_fetch,
  input logic [TAG_W-1:0] req_tag,
  input logic [9:0]       region_sel,
  input logic [6:0]       slot_idx,
  input logic [11:0]      reg_off,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic [TAG_W-1:0] rsp_tag
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(region_sel)); // R1
  AST_RESERVED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && region_sel == 10'd0) |=> rsp_err); // R3
  AST_FETCH_PERIPH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_fetch && |region_sel[8:6]) |=> rsp_err); // R4
  AST_FLASH_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && region_sel[0]) |=> rsp_err); // R5
  AST_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (region_sel[8:6] == 3'b000) |-> (slot_idx == 7'd0)); // R6
  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (region_sel[8:6] == 3'b000) |-> (reg_off == 12'd0)); // R7
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_valid && rsp_tag == $past(req_tag))); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_err)); // R8
  AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid); // R8
endmodule

bind memmap_decode memmap_decode_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_fetch(req_fetch), .req_tag(req_tag), .region_sel(region_sel),
  .slot_idx(slot_idx), .reg_off(reg_off), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_tag(rsp_tag)
);

// File: tb/memmap_decode_tb.sv
module memmap_decode_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_fetch = 1'b0;
  logic [3:0]  req_tag = '0;
  logic [9:0]  region_sel;
  logic [6:0]  slot_idx;
  logic [11:0] reg_off;
  logic        rsp_valid, rsp_err;
  logic [3:0]  rsp_tag;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memmap_decode u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_fetch(req_fetch), .req_tag(req_tag),
    .region_sel(region_sel), .slot_idx(slot_idx), .reg_off(reg_off),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_tag(rsp_tag)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input bit wr, input bit fe,
                        input logic [3:0] tg, input logic [9:0] e_sel,
                        input logic [6:0] e_slot, input logic [11:0] e_off,
                        input bit e_err, input string rq);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_fetch = fe; req_tag = tg;
    #1;
    check(region_sel == e_sel, rq, "region_sel", 32'(region_sel), 32'(e_sel));
    check(slot_idx == e_slot, rq, "slot_idx", 32'(slot_idx), 32'(e_slot));
    check(reg_off == e_off, rq, "reg_off", 32'(reg_off), 32'(e_off));
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_fetch = 1'b0;
    check(rsp_valid == 1'b1, "R8", "rsp_valid", 32'(rsp_valid), 32'd1);
    check(rsp_tag == tg, "R8", "rsp_tag", 32'(rsp_tag), 32'(tg));
    check(rsp_err == e_err, rq, "rsp_err", 32'(rsp_err), 32'(e_err));
  endtask

  task automatic test_reset;
    #1;
    check(rsp_valid == 1'b0, "R9", "rsp_valid in reset", 32'(rsp_valid), 0);
    check(rsp_err == 1'b0, "R9", "rsp_err in reset", 32'(rsp_err), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic test_memories; // R1
    access(32'h0000_1000, 0, 1, 4'h1, 10'h001, 0, 0, 0, "R1");
    access(32'h1000_0040, 0, 0, 4'h2, 10'h002, 0, 0, 0, "R1");
    access(32'h1FFF_1FFC, 0, 1, 4'h3, 10'h004, 0, 0, 0, "R1");
    access(32'h2007_C000, 1, 0, 4'h4, 10'h008, 0, 0, 0, "R1");
    access(32'h2008_3FFC, 1, 0, 4'h5, 10'h010, 0, 0, 0, "R1");
    access(32'h2009_C010, 1, 1, 4'h6, 10'h020, 0, 0, 0, "R1");
    access(32'hE000_E010, 0, 1, 4'h7, 10'h200, 0, 0, 0, "R1");
  endtask

  task automatic test_sizes; // R2
    access(32'h0007_FFFC, 0, 0, 4'h8, 10'h001, 0, 0, 0, "R2");
    access(32'h0008_0000, 0, 0, 4'h9, 10'h000, 0, 0, 1, "R2");
    access(32'h1000_7FFC, 0, 0, 4'hA, 10'h002, 0, 0, 0, "R2");
    access(32'h1000_8000, 1, 0, 4'hB, 10'h000, 0, 0, 1, "R2");
  endtask

  task automatic test_reserved; // R3
    access(32'h1FFF_2000, 0, 0, 4'hC, 10'h000, 0, 0, 1, "R3");
    access(32'h2008_4000, 0, 1, 4'hD, 10'h000, 0, 0, 1, "R3");
    access(32'h5020_0000, 0, 0, 4'hE, 10'h000, 0, 0, 1, "R3");
    access(32'hE010_0000, 0, 1, 4'hF, 10'h000, 0, 0, 1, "R3");
    access(32'hFFFF_FFFC, 1, 0, 4'h0, 10'h000, 0, 0, 1, "R3");
  endtask

  task automatic test_fetch; // R4
    access(32'h4000_C008, 0, 0, 4'h1, 10'h040, 7'd3, 12'h002, 0, "R4");
    access(32'h4000_C008, 0, 1, 4'h2, 10'h040, 7'd3, 12'h002, 1, "R4");
    access(32'h400F_C140, 0, 1, 4'h3, 10'h080, 7'd63, 12'h050, 1, "R4");
    access(32'h5000_8004, 0, 1, 4'h4, 10'h100, 7'd2, 12'h001, 1, "R4");
  endtask

  task automatic test_flash_write; // R5
    access(32'h0000_0000, 1, 0, 4'h5, 10'h001, 0, 0, 1, "R5");
    access(32'h0007_FFFC, 1, 0, 4'h6, 10'h001, 0, 0, 1, "R5");
    access(32'h0007_FFFC, 0, 1, 4'h7, 10'h001, 0, 0, 0, "R5");
  endtask

  task automatic test_slots; // R6 R7
    access(32'h4000_0000, 1, 0, 4'h8, 10'h040, 7'd0, 12'h000, 0, "R6");
    access(32'h4008_0000, 0, 0, 4'h9, 10'h080, 7'd32, 12'h000, 0, "R6");
    access(32'h400F_C140, 1, 0, 4'hA, 10'h080, 7'd63, 12'h050, 0, "R6");
    access(32'h501F_FFFC, 0, 0, 4'hB, 10'h100, 7'd127, 12'hFFF, 0, "R6");
    access(32'h4000_D000, 0, 0, 4'hC, 10'h040, 7'd3, 12'h400, 0, "R7");
    access(32'h5000_BFFF, 1, 0, 4'hD, 10'h100, 7'd2, 12'hFFF, 0, "R7");
  endtask

  task automatic test_idle; // R8
    @(negedge clk);
    check(rsp_valid == 1'b0, "R8", "idle rsp_valid", 32'(rsp_valid), 0);
    check(rsp_err == 1'b0, "R8", "idle rsp_err", 32'(rsp_err), 0);
    req_addr = 32'hFFFF_0000;
    @(negedge clk);
    check(rsp_err == 1'b0, "R8", "idle reserved addr rsp_err", 32'(rsp_err), 0);
  endtask

  initial begin
    test_reset();
    test_memories();
    test_sizes();
    test_reserved();
    test_fetch();
    test_flash_write();
    test_slots();
    test_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule